// File: doc/BRIEF.md
# Slave Sync Lock with Embedded-Code Detection

This block locks horizontal byte phase, line count and field parity to an external video source. It watches a single 8-bit bus that carries 4:2:2 samples multiplexed as Cb, Y, Cr, Y. It also has separate active-low horizontal and vertical sync inputs. When the byte stream carries ITU-R 656 timing codes, the block follows them and pays no attention to the sync pins. When no codes arrive, the falling edges of the sync pins drive the timing.

Each output is registered and describes the byte sampled on the previous clock. The outputs are a 2-bit phase tag (0 = Cb, 1 = Y, 2 = Cr, 3 = Y), a one-cycle start-of-line pulse, a field flag (0 = odd, 1 = even), a line counter and a flag that shows embedded codes are present. The data path stays outside the block. Downstream logic uses the tags to route samples and to count lines.

Top module: `slave_sync_lock`

## Requirements
- R1: After reset, `phase_tag` is 0, `sol` is 0, `field_even` is 0, `line_no` is 0 and `eav_present` is 0.
- R2: A timing code is the byte run FF, 00, 00, XY where bit 7 of XY is 1. `eav_present` is 1 in the output cycle that describes XY. A run whose XY has bit 7 at 0 is not a code.
- R3: An EAV is a code whose XY has bit 4 at 1. The phase tag for the XY byte is 0, and the following bytes are tagged 1, 2, 3, 0 and so on. `sol` pulses for one cycle together with the tag of the byte four slots after XY.
- R4: In code mode, `field_even` takes XY bit 6 at each EAV. `line_no` increments at every `sol`. At the first `sol` after a change of field, `line_no` is 1 instead.
- R5: While `eav_present` is 1, falling edges on `hsync` and `vsync` change none of the outputs.
- R6: `eav_present` falls in the output cycle that describes the byte LOSS_SLOTS slots after the last code's XY byte. A new XY byte in exactly that slot keeps the flag high without a gap.
- R7: In pin mode with `align_y` at 0, the byte on which `hsync` is first low is tagged 0. `sol` pulses with that tag and `line_no` increments.
- R8: In pin mode with `align_y` at 1, the byte on which `hsync` is first low is tagged 1, and `sol` pulses with that tag.
- R9: In pin mode, when `vsync` and `hsync` fall on the same byte, an odd field starts: `field_even` becomes 0 and `line_no` becomes 1.
- R10: In pin mode, when `vsync` falls while `hsync` is high, an even field starts: `field_even` becomes 1, and the next `hsync` fall sets `line_no` to 1.
- R11: A code whose XY has bit 4 at 0 sets `eav_present` but produces no `sol` and does not reset the phase.
- R12: When the first code after loss arrives on the byte where `hsync` falls, the code wins. The tag is 0 and there is no `sol` from the pin, whatever `align_y` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_in | input | 8 | Multiplexed 4:2:2 byte stream |
| hsync | input | 1 | Active-low horizontal sync |
| vsync | input | 1 | Active-low vertical sync |
| align_y | input | 1 | Pin-sync alignment: 0 means the hsync fall is on Cb0, 1 means it is on Y0 |
| phase_tag | output | 2 | Tag of the previous byte: 0 Cb, 1 Y, 2 Cr, 3 Y |
| sol | output | 1 | Start-of-line pulse |
| field_even | output | 1 | 0 = odd field, 1 = even field |
| line_no | output | LINE_W | Line within the field, counted from 1 |
| eav_present | output | 1 | Embedded timing codes are being received |

## Verification
Two functions can fall on the same byte. The first is an embedded code completing while the pin logic sees an `hsync` fall. The bench provokes this after a loss: it drops `hsync` on the XY byte with `align_y` at 1, so a pin-mode result would differ from a code result in both tag and pulse. It judges the case by tag 0, no pulse and the code's field. The second coincidence is a code arriving in the exact slot where the silence window would expire. The bench places the keep-alive XY at that slot and requires `eav_present` to stay high on every byte.

// File: rtl/slave_sync_lock.sv
module slave_sync_lock #(
  parameter int LOSS_SLOTS = 3456,
  parameter int LINE_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        pix_in,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              align_y,
  output logic [1:0]        phase_tag,
  output logic              sol,
  output logic              field_even,
  output logic [LINE_W-1:0] line_no,
  output logic              eav_present
);
  localparam int SIL_W = $clog2(LOSS_SLOTS + 1);

  logic [7:0]       b1, b2, b3;
  logic             hs_q, vs_q;
  logic [2:0]       pend;
  logic             lreset;
  logic [SIL_W-1:0] sil;

  wire code     = (b3 == 8'hFF) && (b2 == 8'h00) && (b1 == 8'h00) && pix_in[7];
  wire eav_hit  = code && pix_in[4];
  wire emode    = eav_present || code;
  wire hs_fall  = hs_q && !hsync && !emode;
  wire vs_fall  = vs_q && !vsync && !emode;
  wire fs_code  = eav_hit && (pix_in[6] != field_even);
  wire fs_pin   = vs_fall && (hs_fall || hsync);
  wire f_start  = fs_code || fs_pin;
  wire new_fld  = eav_hit ? pix_in[6] : !hs_fall;
  wire line_tick = hs_fall || (pend == 3'd1 && !eav_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1 <= 8'h00;
      b2 <= 8'h00;
      b3 <= 8'h00;
      hs_q <= 1'b1;
      vs_q <= 1'b1;
    end else begin
      b1 <= pix_in;
      b2 <= b1;
      b3 <= b2;
      hs_q <= hsync;
      vs_q <= vsync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_tag <= 2'd0;
      pend      <= 3'd0;
      sol       <= 1'b0;
    end else begin
      if (eav_hit)      phase_tag <= 2'd0;
      else if (hs_fall) phase_tag <= align_y ? 2'd1 : 2'd0;
      else              phase_tag <= phase_tag + 2'd1;
      if (eav_hit)           pend <= 3'd4;
      else if (pend != 3'd0) pend <= pend - 3'd1;
      sol <= line_tick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_no    <= '0;
      lreset     <= 1'b0;
      field_even <= 1'b0;
    end else begin
      if (line_tick) begin
        line_no <= (lreset || f_start) ? LINE_W'(1) : line_no + LINE_W'(1);
        lreset  <= 1'b0;
      end else if (f_start) begin
        lreset  <= 1'b1;
      end
      if (f_start) field_even <= new_fld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eav_present <= 1'b0;
      sil         <= '0;
    end else if (code) begin
      eav_present <= 1'b1;
      sil         <= '0;
    end else if (eav_present) begin
      if (sil == SIL_W'(LOSS_SLOTS - 1)) begin
        eav_present <= 1'b0;
        sil         <= '0;
      end else begin
        sil <= sil + SIL_W'(1);
      end
    end
  end

  // R2
  code_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code |=> eav_present);

  // R3
  eav_sol_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sol && eav_present) |-> (phase_tag == 2'd0));

  // R5
  pins_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eav_present && !eav_hit) |=> $stable(field_even));

  // R6
  loss_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eav_present) |-> ($past(sil) == SIL_W'(LOSS_SLOTS - 1)));

  // R7
  sol_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sol |=> !sol);

  // R4
  line_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sol |-> (line_no != '0));
endmodule

// File: tb/slave_sync_lock_tb.sv
module slave_sync_lock_tb;
  localparam int LOSS = 3456;
  localparam int LW   = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    pix_in = 8'h10;
  logic          hsync = 1'b1, vsync = 1'b1, align_y = 1'b0;
  logic [1:0]    phase_tag;
  logic          sol, field_even, eav_present;
  logic [LW-1:0] line_no;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slave_sync_lock #(.LOSS_SLOTS(LOSS), .LINE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .hsync(hsync), .vsync(vsync),
    .align_y(align_y), .phase_tag(phase_tag), .sol(sol), .field_even(field_even),
    .line_no(line_no), .eav_present(eav_present));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic h, input logic v);
    @(negedge clk);
    pix_in = b; hsync = h; vsync = v;
    @(posedge clk);
    #1;
  endtask

  task automatic send_code(input logic [7:0] xy, input logic h_on_xy);
    put(8'hFF, 1, 1); put(8'h00, 1, 1); put(8'h00, 1, 1);
    put(xy, h_on_xy, 1);
  endtask

  task automatic t_reset();
    check("R1 phase", phase_tag, 0);
    check("R1 sol", sol, 0);
    check("R1 field", field_even, 0);
    check("R1 line", line_no, 0);
    check("R1 eav", eav_present, 0);
  endtask

  task automatic t_bad_code();
    send_code(8'h10, 1);
    check("R2 bit7 clear not a code", eav_present, 0);
  endtask

  task automatic t_pin_lines();
    align_y = 0;
    repeat (3) put(8'h80, 1, 1);
    put(8'h10, 0, 1);
    check("R7 sol", sol, 1);
    check("R7 phase", phase_tag, 0);
    check("R7 line", line_no, 1);
    put(8'h10, 0, 1);
    check("R7 phase step", phase_tag, 1);
    check("R7 single sol", sol, 0);
    repeat (2) put(8'h10, 1, 1);
    align_y = 1;
    put(8'h10, 0, 1);
    check("R8 sol", sol, 1);
    check("R8 phase", phase_tag, 1);
    check("R8 line", line_no, 2);
    put(8'h10, 1, 1);
  endtask

  task automatic t_pin_fields();
    put(8'h10, 1, 0);
    check("R10 even field", field_even, 1);
    check("R10 no sol", sol, 0);
    put(8'h10, 1, 0);
    put(8'h10, 0, 0);
    check("R10 line restart", line_no, 1);
    check("R10 sol", sol, 1);
    put(8'h10, 1, 1); put(8'h10, 1, 1);
    put(8'h10, 0, 0);
    check("R9 odd field", field_even, 0);
    check("R9 line", line_no, 1);
    check("R9 sol", sol, 1);
    put(8'h10, 1, 1);
  endtask

  task automatic t_eav();
    send_code(8'h90, 1);
    check("R2 eav present", eav_present, 1);
    check("R3 xy phase", phase_tag, 0);
    for (int i = 1; i <= 3; i++) begin
      put(8'h10, 1, 1);
      check("R3 phase seq", phase_tag, i);
      check("R3 no early sol", sol, 0);
    end
    put(8'h10, 1, 1);
    check("R3 sol", sol, 1);
    check("R3 sol phase", phase_tag, 0);
    check("R4 line inc", line_no, 2);
  endtask

  task automatic t_sav();
    int sols = 0;
    send_code(8'h80, 1);
    check("R11 eav present", eav_present, 1);
    for (int i = 0; i < 6; i++) begin
      put(8'h10, 1, 1);
      if (sol) sols++;
    end
    check("R11 no sol", sols, 0);
  endtask

  task automatic t_field_change();
    send_code(8'hD0, 1);
    check("R4 field follows F", field_even, 1);
    repeat (3) put(8'h10, 1, 1);
    put(8'h10, 1, 1);
    check("R4 sol", sol, 1);
    check("R4 line restart", line_no, 1);
    put(8'h10, 0, 0);
    check("R5 no sol from pin", sol, 0);
    check("R5 field kept", field_even, 1);
    check("R5 phase continues", phase_tag, 1);
    put(8'h10, 1, 1);
  endtask

  task automatic t_loss();
    int drops = 0;
    send_code(8'hD0, 1);
    for (int i = 0; i < LOSS - 4; i++) begin
      put(8'h10, 1, 1);
      if (!eav_present) drops++;
    end
    put(8'hFF, 1, 1); if (!eav_present) drops++;
    put(8'h00, 1, 1); if (!eav_present) drops++;
    put(8'h00, 1, 1); if (!eav_present) drops++;
    put(8'hD0, 1, 1); if (!eav_present) drops++;
    check("R6 keep-alive at window edge", drops, 0);
    for (int i = 0; i < LOSS - 1; i++) put(8'h10, 1, 1);
    check("R6 still present", eav_present, 1);
    put(8'h10, 1, 1);
    check("R6 lost", eav_present, 0);
  endtask

  task automatic t_coincide();
    align_y = 1;
    send_code(8'h90, 0);
    check("R12 eav", eav_present, 1);
    check("R12 no pin sol", sol, 0);
    check("R12 phase", phase_tag, 0);
    check("R12 field from code", field_even, 0);
    repeat (3) put(8'h10, 0, 1);
    put(8'h10, 0, 1);
    check("R12 code sol", sol, 1);
    check("R12 line", line_no, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    put(8'h10, 1, 1);
    t_bad_code();
    t_pin_lines();
    t_pin_fields();
    t_eav();
    t_sav();
    t_field_change();
    t_loss();
    t_coincide();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule